// File: doc/BRIEF.md
# Dual-Lane Correlation Threshold Checker

This block sits behind two parallel accumulator lanes that work on a pair of neighbouring pixels. Each lane delivers four sums: target hot, target cold, background hot and background cold. One shared score-and-compare path serves both lanes in turn. It forms a signed correlation score for each lane and raises a region-of-interest flag when that score reaches a programmable threshold. Each result leaves on one result port together with the lane index and the pixel location.

The block runs on one clock. A two-cycle lane slot is built from a phase toggle held in the controller. Lane inputs are taken once per slot. Lane 0 is evaluated in the second cycle of the slot and lane 1 in the first cycle of the next slot, so the shared path runs at twice the lane rate and each lane gets its own result cycle. No result is ever dropped. The threshold register can only be written while the block is idle, and it stays fixed for the whole frame.

The controller has four states. ST_IDLE accepts threshold loads and moves to ST_SLOT_A when `run` is high. ST_SLOT_A samples both lanes and serves lane 1 of the previous slot, then always moves to ST_SLOT_B. ST_SLOT_B serves lane 0 and returns to ST_SLOT_A while `run` is high; otherwise it moves to ST_DRAIN. ST_DRAIN serves the last lane 1, clears the held lane valids and always returns to ST_IDLE.

Top module: `corr_roi_top`

## Requirements
- R1: After reset, `res_valid` and `lane_take` are low and the threshold holds its reset value of 0, so a score of 0 is flagged and a score of -1 is not.
- R2: While running, `lane_take` is high on every other cycle. Lane inputs and `in_loc` are sampled only at a rising edge where `lane_take` is high; values presented at other edges have no effect on any result.
- R3: A valid lane 0 sample taken at edge E gives a result at edge E+2. A valid lane 1 sample taken at E gives a result at edge E+3.
- R4: Each sums bus is packed as target hot [4W-1:3W], target cold [3W-1:2W], background hot [2W-1:W] and background cold [W-1:0], where W is SUM_W. The score is the signed value (target hot + background cold) - (target cold + background hot), and `res_roi` is 1 exactly when score >= threshold, including equality.
- R5: The threshold is compared as a two's-complement signed value, so negative thresholds flag negative scores that are at or above them.
- R6: A lane 0 result carries `in_loc`. A lane 1 result carries `in_loc` + 1, which wraps modulo 2^LOC_W.
- R7: A lane whose valid is low in a slot produces no result: `res_valid` stays low in that lane's result cycle.
- R8: `thr_load` writes `thr_value` only in the idle state. A load attempted while running leaves the threshold unchanged.
- R9: When `run` falls, the results of the last sampled slot are still delivered. The block then takes no further samples and returns to idle in the cycle after the drain cycle.
- R10: `res_lane` is 0 for a lane 0 result and 1 for a lane 1 result. When both lanes are valid, lane 0 comes out one cycle before lane 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| run | input | 1 | Frame in progress; low requests a drain to idle |
| thr_load | input | 1 | Threshold write strobe, honoured only when idle |
| thr_value | input | SUM_W+2 | Signed threshold value |
| lane_take | output | 1 | High in cycles whose closing edge samples the lanes |
| in0_valid | input | 1 | Lane 0 sums valid |
| in0_sums | input | 4*SUM_W | Lane 0 sums, packed as in R4 |
| in1_valid | input | 1 | Lane 1 sums valid |
| in1_sums | input | 4*SUM_W | Lane 1 sums, packed as in R4 |
| in_loc | input | LOC_W | Pixel location of lane 0 |
| res_valid | output | 1 | Result present |
| res_lane | output | 1 | Lane index of the result |
| res_loc | output | LOC_W | Pixel location of the result |
| res_roi | output | 1 | Region-of-interest flag |

## Verification
Inputs sampled at edge E produce a lane 0 result at edge E+2 and a lane 1 result at edge E+3. The bench drives each slot in the half-cycle before a sampling edge and books each expected result two or three half-cycle samples later. Every cycle in which nothing is booked is checked for `res_valid` low. On non-sampling cycles the bench drives random junk on the lane inputs, so any sampling outside `lane_take` shows up as a wrong result. The drain is covered the same way: the last slot's two results are booked before `run` falls and are checked in the drain and idle cycles.

// File: rtl/corr_roi_pkg.sv
`timescale 1ns/1ps
package corr_roi_pkg;
    localparam int NUM_LANES = 2;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SLOT_A = 2'd1,
        ST_SLOT_B = 2'd2,
        ST_DRAIN  = 2'd3
    } corr_state_e;
endpackage

// File: rtl/corr_roi_fsm.sv
`timescale 1ns/1ps
module corr_roi_fsm
    import corr_roi_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        run,
    output corr_state_e state,
    output logic        capture_en,
    output logic        serve_en,
    output logic        serve_lane,
    output logic        drain_clr,
    output logic        idle
);
    corr_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (run) state_d = ST_SLOT_A;
            ST_SLOT_A: state_d = ST_SLOT_B;
            ST_SLOT_B: state_d = run ? ST_SLOT_A : ST_DRAIN;
            ST_DRAIN:  state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        capture_en = 1'b0;
        serve_en   = 1'b0;
        serve_lane = 1'b0;
        drain_clr  = 1'b0;
        idle       = 1'b0;
        unique case (state_q)
            ST_IDLE:   idle = 1'b1;
            ST_SLOT_A: begin
                capture_en = 1'b1;
                serve_en   = 1'b1;
                serve_lane = 1'b1;
            end
            ST_SLOT_B: begin
                serve_en   = 1'b1;
                serve_lane = 1'b0;
            end
            ST_DRAIN:  begin
                serve_en   = 1'b1;
                serve_lane = 1'b1;
                drain_clr  = 1'b1;
            end
            default:   idle = 1'b1;
        endcase
    end

    assign state = state_q;
endmodule

// File: rtl/corr_lane_hold.sv
`timescale 1ns/1ps
module corr_lane_hold #(
    parameter int SUM_W   = 10,
    parameter int LOC_W   = 12,
    parameter int LOC_OFS = 0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               capture,
    input  logic               clear,
    input  logic               in_valid,
    input  logic [4*SUM_W-1:0] in_sums,
    input  logic [LOC_W-1:0]   in_loc,
    output logic               valid_q,
    output logic [4*SUM_W-1:0] sums_q,
    output logic [LOC_W-1:0]   loc_q
);
    localparam logic [LOC_W-1:0] OFS = LOC_W'(LOC_OFS);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            sums_q  <= '0;
            loc_q   <= '0;
        end else if (capture) begin
            valid_q <= in_valid;
            sums_q  <= in_sums;
            loc_q   <= in_loc + OFS;
        end else if (clear) begin
            valid_q <= 1'b0;
        end
    end
endmodule

// File: rtl/corr_score_cmp.sv
`timescale 1ns/1ps
module corr_score_cmp #(
    parameter int SUM_W = 10
) (
    input  logic [4*SUM_W-1:0]       sums,
    input  logic signed [SUM_W+1:0]  thr,
    output logic                     roi
);
    localparam int SCORE_W = SUM_W + 2;

    logic [SUM_W-1:0] tgt_hot, tgt_cold, bkg_hot, bkg_cold;
    logic signed [SCORE_W-1:0] agree, disagree, score;

    always_comb begin
        tgt_hot  = sums[4*SUM_W-1:3*SUM_W];
        tgt_cold = sums[3*SUM_W-1:2*SUM_W];
        bkg_hot  = sums[2*SUM_W-1:SUM_W];
        bkg_cold = sums[SUM_W-1:0];
        agree    = $signed({2'b00, tgt_hot})  + $signed({2'b00, bkg_cold});
        disagree = $signed({2'b00, tgt_cold}) + $signed({2'b00, bkg_hot});
        score    = agree - disagree;
        roi      = (score >= thr);
    end
endmodule

// File: rtl/corr_roi_top.sv
`timescale 1ns/1ps
module corr_roi_top
    import corr_roi_pkg::*;
#(
    parameter int SUM_W    = 10,
    parameter int LOC_W    = 12,
    parameter int THR_INIT = 0
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   run,
    input  logic                   thr_load,
    input  logic [SUM_W+1:0]       thr_value,
    output logic                   lane_take,
    input  logic                   in0_valid,
    input  logic [4*SUM_W-1:0]     in0_sums,
    input  logic                   in1_valid,
    input  logic [4*SUM_W-1:0]     in1_sums,
    input  logic [LOC_W-1:0]       in_loc,
    output logic                   res_valid,
    output logic                   res_lane,
    output logic [LOC_W-1:0]       res_loc,
    output logic                   res_roi
);
    localparam int SCORE_W = SUM_W + 2;
    localparam int PACK_W  = 4 * SUM_W;

    corr_state_e fsm_state;
    logic capture_en, serve_en, serve_lane, drain_clr, idle;

    corr_roi_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run),
        .state      (fsm_state),
        .capture_en (capture_en),
        .serve_en   (serve_en),
        .serve_lane (serve_lane),
        .drain_clr  (drain_clr),
        .idle       (idle)
    );

    logic signed [SCORE_W-1:0] thr_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                thr_q <= SCORE_W'(THR_INIT);
        else if (idle && thr_load) thr_q <= thr_value;
    end

    logic [NUM_LANES-1:0] in_v;
    logic [PACK_W-1:0]    in_s   [NUM_LANES];
    logic [NUM_LANES-1:0] lane_v;
    logic [PACK_W-1:0]    lane_s [NUM_LANES];
    logic [LOC_W-1:0]     lane_l [NUM_LANES];

    assign in_v    = {in1_valid, in0_valid};
    assign in_s[0] = in0_sums;
    assign in_s[1] = in1_sums;

    for (genvar g = 0; g < NUM_LANES; g++) begin : gen_lane
        corr_lane_hold #(
            .SUM_W   (SUM_W),
            .LOC_W   (LOC_W),
            .LOC_OFS (g)
        ) u_hold (
            .clk      (clk),
            .rst_n    (rst_n),
            .capture  (capture_en),
            .clear    (drain_clr),
            .in_valid (in_v[g]),
            .in_sums  (in_s[g]),
            .in_loc   (in_loc),
            .valid_q  (lane_v[g]),
            .sums_q   (lane_s[g]),
            .loc_q    (lane_l[g])
        );
    end

    logic              sel_v;
    logic [PACK_W-1:0] sel_s;
    logic [LOC_W-1:0]  sel_l;
    logic              sel_roi;

    always_comb begin
        sel_v = lane_v[serve_lane];
        sel_s = lane_s[serve_lane];
        sel_l = lane_l[serve_lane];
    end

    corr_score_cmp #(.SUM_W(SUM_W)) u_cmp (
        .sums (sel_s),
        .thr  (thr_q),
        .roi  (sel_roi)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_lane  <= 1'b0;
            res_loc   <= '0;
            res_roi   <= 1'b0;
        end else if (serve_en && sel_v) begin
            res_valid <= 1'b1;
            res_lane  <= serve_lane;
            res_loc   <= sel_l;
            res_roi   <= sel_roi;
        end else begin
            res_valid <= 1'b0;
            res_roi   <= 1'b0;
        end
    end

    assign lane_take = capture_en;
endmodule

// File: rtl/corr_roi_sva.sv
`timescale 1ns/1ps
module corr_roi_sva
    import corr_roi_pkg::*;
#(
    parameter int LOC_W   = 12,
    parameter int SCORE_W = 12
) (
    input logic               clk,
    input logic               rst_n,
    input logic               lane_take,
    input logic               in0_valid,
    input logic               in1_valid,
    input logic [LOC_W-1:0]   in_loc,
    input logic               res_valid,
    input logic               res_lane,
    input logic [LOC_W-1:0]   res_loc,
    input logic [SCORE_W-1:0] thr_q,
    input corr_state_e        fsm_state
);
    // R2
    take_alternates_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lane_take |=> !lane_take);

    // R3
    lane0_due_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(lane_take, 2) && $past(in0_valid, 2)) |-> (res_valid && !res_lane));

    // R6
    lane1_loc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(lane_take, 3) && $past(in1_valid, 3)) |->
            (res_valid && res_lane && res_loc == LOC_W'($past(in_loc, 3) + 1'b1)));

    // R7
    no_phantom_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(lane_take, 2) && !$past(in0_valid, 2)) |-> !res_valid);

    // R8
    thr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state != ST_IDLE) |=> $stable(thr_q));

    // R9
    drain_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == ST_DRAIN) |=> (fsm_state == ST_IDLE && !lane_take));
endmodule

bind corr_roi_top corr_roi_sva #(
    .LOC_W   (LOC_W),
    .SCORE_W (SCORE_W)
) u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .lane_take (lane_take),
    .in0_valid (in0_valid),
    .in1_valid (in1_valid),
    .in_loc    (in_loc),
    .res_valid (res_valid),
    .res_lane  (res_lane),
    .res_loc   (res_loc),
    .thr_q     (thr_q),
    .fsm_state (fsm_state)
);

// File: tb/corr_roi_top_tb.sv
`timescale 1ns/1ps
module corr_roi_top_tb;
    localparam int SUM_W   = 10;
    localparam int LOC_W   = 12;
    localparam int SCORE_W = SUM_W + 2;
    localparam int DEPTH   = 8192;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic run = 1'b0;
    logic thr_load = 1'b0;
    logic [SCORE_W-1:0] thr_value = '0;
    logic lane_take;
    logic in0_valid = 1'b0, in1_valid = 1'b0;
    logic [4*SUM_W-1:0] in0_sums = '0, in1_sums = '0;
    logic [LOC_W-1:0] in_loc = '0;
    logic res_valid, res_lane, res_roi;
    logic [LOC_W-1:0] res_loc;

    always #10 clk = ~clk;

    corr_roi_top #(.SUM_W(SUM_W), .LOC_W(LOC_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .run(run), .thr_load(thr_load),
        .thr_value(thr_value), .lane_take(lane_take),
        .in0_valid(in0_valid), .in0_sums(in0_sums),
        .in1_valid(in1_valid), .in1_sums(in1_sums), .in_loc(in_loc),
        .res_valid(res_valid), .res_lane(res_lane), .res_loc(res_loc),
        .res_roi(res_roi)
    );

    int n_chk = 0, n_fail = 0, cyc = 0, model_thr = 0;
    bit done = 1'b0;
    bit ev [DEPTH];
    bit el [DEPTH];
    bit er [DEPTH];
    logic [LOC_W-1:0] eloc [DEPTH];

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [4*SUM_W-1:0] pack(input int th, input int tc,
                                                input int bh, input int bc);
        return {SUM_W'(th), SUM_W'(tc), SUM_W'(bh), SUM_W'(bc)};
    endfunction

    function automatic bit roi_model(input logic [4*SUM_W-1:0] s, input int thr);
        int th, tc, bh, bc;
        th = int'(s[4*SUM_W-1:3*SUM_W]);
        tc = int'(s[3*SUM_W-1:2*SUM_W]);
        bh = int'(s[2*SUM_W-1:SUM_W]);
        bc = int'(s[SUM_W-1:0]);
        return ((th + bc) - (tc + bh)) >= thr;
    endfunction

    function automatic logic [4*SUM_W-1:0] rand_sums();
        int m;
        m = ($urandom % 2 == 0) ? 16 : (1 << SUM_W);
        return pack($urandom % m, $urandom % m, $urandom % m, $urandom % m);
    endfunction

    task automatic tick();
        @(negedge clk);
        cyc++;
        if (ev[cyc]) begin
            chk(res_valid == 1'b1, "R3", "result due", int'(res_valid), 1);
            chk(res_lane == el[cyc], "R10", "lane index", int'(res_lane), int'(el[cyc]));
            chk(res_loc == eloc[cyc], "R6", "location", int'(res_loc), int'(eloc[cyc]));
            chk(res_roi == er[cyc], "R4", "roi flag", int'(res_roi), int'(er[cyc]));
        end else begin
            chk(res_valid == 1'b0, "R7", "no result expected", int'(res_valid), 0);
        end
        // junk between sampling edges (R2): must never reach a result
        in0_valid = 1'($urandom);
        in1_valid = 1'($urandom);
        in0_sums  = rand_sums();
        in1_sums  = rand_sums();
        in_loc    = LOC_W'($urandom);
    endtask

    task automatic drive_slot(input bit v0, input logic [4*SUM_W-1:0] s0,
                              input bit v1, input logic [4*SUM_W-1:0] s1,
                              input logic [LOC_W-1:0] loc);
        int guard = 0;
        do begin
            tick();
            guard++;
        end while (!lane_take && guard < 8);
        chk(lane_take == 1'b1, "R2", "sampling cycle reached", int'(lane_take), 1);
        in0_valid = v0; in0_sums = s0;
        in1_valid = v1; in1_sums = s1;
        in_loc    = loc;
        thr_load  = 1'b0;
        if (v0) begin
            ev[cyc+2] = 1'b1; el[cyc+2] = 1'b0;
            eloc[cyc+2] = loc; er[cyc+2] = roi_model(s0, model_thr);
        end
        if (v1) begin
            ev[cyc+3] = 1'b1; el[cyc+3] = 1'b1;
            eloc[cyc+3] = loc + 1'b1; er[cyc+3] = roi_model(s1, model_thr);
        end
        tick();
        chk(lane_take == 1'b0, "R2", "take alternates", int'(lane_take), 0);
    endtask

    task automatic rand_slot();
        drive_slot(1'($urandom), rand_sums(), 1'($urandom), rand_sums(),
                   LOC_W'($urandom));
    endtask

    task automatic end_frame();
        run = 1'b0;
        for (int i = 0; i < 4; i++) begin
            tick();
            chk(lane_take == 1'b0, "R9", "no sampling after run falls", int'(lane_take), 0);
        end
    endtask

    task automatic load_thr(input int v);
        thr_value = SCORE_W'(v);
        thr_load  = 1'b1;
        tick();
        thr_load  = 1'b0;
        model_thr = v;
    endtask

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        chk(res_valid == 1'b0, "R1", "res_valid in reset", int'(res_valid), 0);
        chk(lane_take == 1'b0, "R1", "lane_take in reset", int'(lane_take), 0);
        rst_n = 1'b1;
        tick();
        tick();

        // R1: reset threshold 0 -> score 0 flagged, -1 not
        run = 1'b1;
        drive_slot(1'b1, pack(5, 5, 3, 3), 1'b1, pack(5, 6, 3, 3), 12'd100);
        drive_slot(1'b1, pack(0, 0, 0, 0), 1'b0, pack(0, 0, 0, 0), 12'd200);
        end_frame();

        // R4: equality and one below, location wrap (R6), single lanes (R7, R10)
        load_thr(7);
        run = 1'b1;
        drive_slot(1'b1, pack(10, 1, 2, 0), 1'b1, pack(9, 1, 2, 0), 12'hFFF);
        drive_slot(1'b0, pack(900, 0, 0, 0), 1'b1, pack(7, 0, 0, 0), 12'd5);
        drive_slot(1'b0, pack(0, 0, 0, 0), 1'b0, pack(0, 0, 0, 0), 12'd6);
        drive_slot(1'b1, pack(0, 900, 0, 0), 1'b0, pack(0, 0, 0, 0), 12'd7);
        // R8: load while running is ignored
        thr_value = SCORE_W'(-100);
        thr_load  = 1'b1;
        drive_slot(1'b1, pack(6, 0, 0, 0), 1'b1, pack(7, 0, 0, 0), 12'd9);
        drive_slot(1'b1, pack(1, 0, 0, 0), 1'b1, pack(1023, 0, 0, 1023), 12'd10);
        for (int i = 0; i < 300; i++) rand_slot();
        end_frame();

        // R5: negative threshold
        load_thr(-20);
        run = 1'b1;
        drive_slot(1'b1, pack(0, 20, 0, 0), 1'b1, pack(0, 21, 0, 0), 12'd300);
        drive_slot(1'b1, pack(0, 1023, 1023, 0), 1'b1, pack(0, 10, 10, 0), 12'd301);
        for (int i = 0; i < 300; i++) rand_slot();
        end_frame();

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end
endmodule